// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a WIDTH-bit register (4 by default) whose next value is chosen on every rising clock edge by a two-bit mode input. The four choices are:

- keep the present value;
- move every bit one place toward index 0;
- move every bit one place toward index WIDTH-1;
- take a new parallel word.

Each shift direction has its own serial input, which fills the bit that the shift leaves empty. A serial output sits at each end of the word, so that several of these registers can be chained.

The mode choice is made by a multiplexer in front of each flip-flop's data input. Every flip-flop is clocked by the same ungated clock, so no skew is added between bits. An active-low asynchronous clear empties the register at once, whatever the mode. Typical uses are serial-to-parallel and parallel-to-serial conversion, or a small data path register that a controller steers one step at a time.

Top module: `bidir_shift_reg`

## Requirements
- R1: While `rst_n` is 0, every bit of `word_out` is 0 at once, without waiting for a clock edge, and this overrides every mode.
- R2: With `mode` = 2'b00, a clock edge leaves `word_out` unchanged.
- R3: With `mode` = 2'b01 (down-shift), a clock edge moves each bit i to bit i-1. Bit WIDTH-1 takes `ser_in_down`.
- R4: With `mode` = 2'b10 (up-shift), a clock edge moves each bit i to bit i+1. Bit 0 takes `ser_in_up`.
- R5: With `mode` = 2'b11, a clock edge copies `par_in` into `word_out`.
- R6: `ser_out_up` always equals `word_out[WIDTH-1]` and `ser_out_down` always equals `word_out[0]`. Both show the bit that the next shift in their direction will push out.
- R7: Inputs the selected mode does not use have no effect. This covers `par_in` outside mode 2'b11, `ser_in_up` outside mode 2'b10, and `ser_in_down` outside mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous clear |
| mode | input | 2 | 00 hold, 01 down-shift, 10 up-shift, 11 load |
| par_in | input | WIDTH | Parallel load word |
| ser_in_up | input | 1 | Fill bit entering at index 0 on an up-shift |
| ser_in_down | input | 1 | Fill bit entering at index WIDTH-1 on a down-shift |
| word_out | output | WIDTH | Register contents |
| ser_out_up | output | 1 | Top bit, the bit leaving on an up-shift |
| ser_out_down | output | 1 | Bit 0, the bit leaving on a down-shift |

## Verification
The bench goes after the edge bits of each shift.

- If the two serial inputs were swapped, a run of down-shifts would fill the top with the up-shift serial input, and the word would drift away from the model.
- If a neighbour index were off by one, a walking one would either stay in place or jump two positions.
- The bench toggles the unused serial input and `par_in` during hold and shift runs. A design that leaked them into the wrong mode would corrupt the word.
- The bench drops the clear between clock edges and checks for a zero word before the next edge. A clear that waited for the clock would fail this check.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD = 2'b00,
      MODE_DOWN = 2'b01,
      MODE_UP   = 2'b10,
      MODE_LOAD = 2'b11
   } bsr_mode_e;

   typedef struct packed {
      logic hold;
      logic down;
      logic up;
      logic load;
   } bsr_sel_t;

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
   import bsr_pkg::*;
(
   input  logic [1:0] mode,
   output bsr_sel_t   sel
);

   bsr_mode_e mode_e;

   always_comb begin
      mode_e = bsr_mode_e'(mode);
      sel    = '0;
      unique case (mode_e)
         MODE_HOLD: sel.hold = 1'b1;
         MODE_DOWN: sel.down = 1'b1;
         MODE_UP:   sel.up   = 1'b1;
         MODE_LOAD: sel.load = 1'b1;
         default:   sel.hold = 1'b1;
      endcase
   end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
   import bsr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bsr_sel_t sel,
   input  logic     from_below,
   input  logic     from_above,
   input  logic     par_bit,
   output logic     q
);

   logic d_next;

   always_comb begin
      d_next = (sel.hold & q)
             | (sel.down & from_above)
             | (sel.up   & from_below)
             | (sel.load & par_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d_next;
   end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
   import bsr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in_up,
   input  logic             ser_in_down,
   output logic [WIDTH-1:0] word_out,
   output logic             ser_out_up,
   output logic             ser_out_down
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("bidir_shift_reg: WIDTH must be at least 2");
   end

   bsr_sel_t         sel;
   logic [WIDTH-1:0] below_bit;
   logic [WIDTH-1:0] above_bit;

   bsr_mode_decode u_dec (
      .mode (mode),
      .sel  (sel)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_low_end
         assign below_bit[i] = ser_in_up;
      end else begin : g_low_mid
         assign below_bit[i] = word_out[i-1];
      end

      if (i == TOP) begin : g_high_end
         assign above_bit[i] = ser_in_down;
      end else begin : g_high_mid
         assign above_bit[i] = word_out[i+1];
      end

      bsr_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel        (sel),
         .from_below (below_bit[i]),
         .from_above (above_bit[i]),
         .par_bit    (par_in[i]),
         .q          (word_out[i])
      );
   end

   assign ser_out_up   = word_out[TOP];
   assign ser_out_down = word_out[0];

endmodule

// File: rtl/bsr_check.sv
module bsr_check #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [WIDTH-1:0] par_in,
   input logic             ser_in_up,
   input logic             ser_in_down,
   input logic [WIDTH-1:0] word_out,
   input logic             ser_out_up,
   input logic             ser_out_down
);

   assert_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (word_out == '0));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> $stable(word_out));

   assert_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> (word_out == {$past(ser_in_down), $past(word_out[WIDTH-1:1])}));

   assert_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> (word_out == {$past(word_out[WIDTH-2:0]), $past(ser_in_up)}));

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> (word_out == $past(par_in)));

   assert_serout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_out_up == word_out[WIDTH-1]) && (ser_out_down == word_out[0]));

endmodule

bind bidir_shift_reg bsr_check #(.WIDTH(WIDTH)) u_bsr_check (.*);

// File: tb/bidir_shift_reg_test.sv
`timescale 1ns/1ps
module bidir_shift_reg_test;

   localparam int W = 4;

   typedef struct {
      logic [W-1:0] word;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic [1:0]   mode = 2'b00;
   logic [W-1:0] par_in = '0;
   logic         ser_in_up = 1'b0;
   logic         ser_in_down = 1'b0;
   logic [W-1:0] word_out;
   logic         ser_out_up;
   logic         ser_out_down;

   logic [W-1:0] model = '0;
   exp_t         sb[$];
   int           n_run = 0;
   int           n_fail = 0;

   always #2 clk = ~clk;

   bidir_shift_reg #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
      .ser_in_up(ser_in_up), .ser_in_down(ser_in_down),
      .word_out(word_out), .ser_out_up(ser_out_up), .ser_out_down(ser_out_down)
   );

   task automatic check_word(input logic [W-1:0] exp, input string tag);
      n_run++;
      if (word_out !== exp) begin
         n_fail++;
         $display("FAIL %s: word_out=%b expected=%b", tag, word_out, exp);
      end
      n_run++;
      if (ser_out_up !== exp[W-1] || ser_out_down !== exp[0]) begin
         n_fail++;
         $display("FAIL R6 (%s): ser_out_up/down=%b%b expected=%b%b",
                  tag, ser_out_up, ser_out_down, exp[W-1], exp[0]);
      end
   endtask

   // driver: apply one cycle of stimulus and push the model's result
   task automatic drive(input logic [1:0] m, input logic [W-1:0] p,
                        input logic su, input logic sd, input string tag);
      exp_t e;
      @(negedge clk);
      mode = m; par_in = p; ser_in_up = su; ser_in_down = sd;
      case (m)
         2'b00: model = model;
         2'b01: model = {sd, model[W-1:1]};
         2'b10: model = {model[W-2:0], su};
         default: model = p;
      endcase
      e.word = model;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // monitor: compare once the edge has settled
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check_word(e.word, e.tag);
      end
   end

   initial begin : watchdog
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      #1 rst_n = 1'b0;
      mode = 2'b11; par_in = 4'hF;
      repeat (2) @(posedge clk);
      #1 check_word('0, "R1 reset state");
      @(negedge clk) rst_n = 1'b1; mode = 2'b00;

      drive(2'b11, 4'b1010, 1'b1, 1'b1, "R5 load 1010");
      drive(2'b00, 4'b0101, 1'b1, 1'b1, "R2/R7 hold ignores inputs");
      drive(2'b00, 4'b1111, 1'b0, 1'b1, "R2 hold again");
      drive(2'b11, 4'b0001, 1'b0, 1'b0, "R5 load 0001");
      for (int k = 0; k < 4; k++)
         drive(2'b10, 4'b1111, 1'b0, 1'b1, "R4/R7 walk one upward, fill 0");
      drive(2'b11, 4'b1000, 1'b0, 1'b0, "R5 load 1000");
      for (int k = 0; k < 4; k++)
         drive(2'b01, 4'b0111, 1'b1, 1'b0, "R3/R7 walk one downward, fill 0");
      for (int k = 0; k < 4; k++)
         drive(2'b10, 4'b0000, k[0], 1'b0, "R4 up-shift serial pattern");
      for (int k = 0; k < 4; k++)
         drive(2'b01, 4'b1111, 1'b0, ~k[1], "R3 down-shift serial pattern");
      drive(2'b11, 4'b0110, 1'b1, 1'b1, "R5 load 0110");
      drive(2'b10, 4'b0000, 1'b1, 1'b0, "R4 shift up fill 1");
      drive(2'b01, 4'b0000, 1'b0, 1'b1, "R3 shift down fill 1");
      drive(2'b11, 4'b1111, 1'b0, 1'b0, "R5 load all ones");
      drive(2'b00, 4'b0000, 1'b0, 1'b0, "R2 hold all ones");

      // asynchronous clear between edges, in load mode
      @(negedge clk);
      mode = 2'b11; par_in = 4'hF;
      #0.5 rst_n = 1'b0;
      #0.5 check_word('0, "R1 clear without clock");
      @(posedge clk);
      #1 check_word('0, "R1 clear overrides load");
      @(negedge clk) rst_n = 1'b1; mode = 2'b00;
      model = '0;
      drive(2'b01, 4'b1111, 1'b1, 1'b1, "R3 fill after clear");
      drive(2'b00, 4'b0000, 1'b0, 1'b0, "R2 final hold");

      @(negedge clk);
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule